// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control state machine of a small accumulator-style processor. It carries every instruction through a loop of phases. It reads the instruction word from memory at the instruction pointer and advances the pointer. It spends one cycle on decode. When the opcode asks for a memory operand, it reads that operand. It then hands the work to an external arithmetic unit and waits for that unit to finish. When the opcode sends its result to memory, it writes the result back. After that it starts the next instruction. The operand read and the result write are each skipped when the opcode does not need them, so the number of cycles an instruction takes depends on its memory traffic, on memory latency and on the arithmetic unit's latency.

An instruction word is `DATA_W` bits wide. The top `DATA_W-ADDR_W` bits are the opcode and the low `ADDR_W` bits are a memory address. A small internal decoder turns the opcode into three flags: operand read, result write and halt. The memory port is synchronous. A strobe stays high until the `mem_ready` input is high at a clock edge.

Top module: `fex_sequencer`

## Requirements
- R1: A clock edge with `rst` high puts the machine in the fetch state (state code 6'b000001), clears `ip` to zero and clears the held operand (`alu_operand` reads zero).
- R2: In fetch, `mem_rd` is high and `mem_addr` equals `ip`. At the edge where `mem_ready` is high, the word on `mem_rdata` becomes the instruction and `ip` increases by one. Until then `ip` holds.
- R3: Decode (state code 6'b000010) lasts exactly one cycle and raises no strobe.
- R4: Operand read (state code 6'b000100) follows decode only when opcode bit 0 is 1 and the opcode is not all ones. Otherwise decode goes straight to execute.
- R5: In operand read, `mem_rd` is high and `mem_addr` equals the low `ADDR_W` bits of the instruction. The word read becomes `alu_operand` and stays there until the next operand read.
- R6: Execute (state code 6'b001000) drives `alu_go` high and holds until `alu_done` is high at an edge. At that edge `alu_result` is captured as the instruction's result.
- R7: Result write (state code 6'b010000) follows execute only when opcode bit 1 is 1. It drives `mem_wr` with `mem_addr` equal to the instruction's address field and `mem_wdata` equal to the captured result. Otherwise execute returns to fetch.
- R8: Every memory phase holds until `mem_ready`. Outside the fetch, operand-read and result-write states, `mem_rd` and `mem_wr` stay low, and the two are never high together.
- R9: An all-ones opcode sends decode to the halt state (state code 6'b100000). The machine then stays there with no strobes and a steady `ip` until reset.
- R10: The `state` output always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Memory address for the current phase |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Data to write in the result-write phase |
| mem_rdata | input | DATA_W | Data returned by memory |
| mem_ready | input | 1 | Memory completes the current access at this edge |
| alu_go | output | 1 | Arithmetic unit should work on the current instruction |
| alu_opcode | output | DATA_W-ADDR_W | Opcode field of the current instruction |
| alu_operand | output | DATA_W | Most recently read memory operand |
| alu_done | input | 1 | Arithmetic unit finishes at this edge |
| alu_result | input | DATA_W | Result from the arithmetic unit |
| ip | output | ADDR_W | Instruction pointer |
| state | output | 6 | One-hot phase code |

## Verification
The bench records the phase code, pointer, strobes and address for every cycle. It compares them against a model that walks the program. It covers opcodes with no memory traffic, with a read only, with a write only and with both, each run with zero and with stretched memory and arithmetic latency. A design that got the skip conditions wrong would show an extra or a missing phase in the trace. A design that ignored `mem_ready` or `alu_done` would leave a phase too early. A design that advanced the pointer at the wrong edge would show a pointer off by one in decode. The halt case checks that the machine stays parked and quiet rather than fetching the word after the halt. The captured words that come back through the write port show whether the operand and the result were latched in the correct cycle.

// File: rtl/fex_pkg.sv
package fex_pkg;

    typedef enum logic [5:0] {
        ST_FETCH  = 6'b000001,
        ST_DECODE = 6'b000010,
        ST_OPRD   = 6'b000100,
        ST_EXEC   = 6'b001000,
        ST_STORE  = 6'b010000,
        ST_HALT   = 6'b100000
    } fex_state_e;

    typedef struct packed {
        logic rd_operand;
        logic wr_result;
        logic halt;
    } fex_dec_t;

endpackage

// File: rtl/fex_decode.sv
module fex_decode
    import fex_pkg::*;
#(
    parameter int OPC_W = 4
) (
    input  logic [OPC_W-1:0] opc,
    output fex_dec_t         dec
);
    logic is_halt;

    always_comb begin
        is_halt        = &opc;
        dec.halt       = is_halt;
        dec.rd_operand = opc[0] & ~is_halt;
        dec.wr_result  = opc[1] & ~is_halt;
    end
endmodule

// File: rtl/fex_mem_port.sv
module fex_mem_port
    import fex_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  fex_state_e        st,
    input  logic [ADDR_W-1:0] ip,
    input  logic [ADDR_W-1:0] field_addr,
    input  logic [DATA_W-1:0] result,
    output logic [ADDR_W-1:0] addr,
    output logic              rd,
    output logic              wr,
    output logic [DATA_W-1:0] wdata
);
    always_comb begin
        addr  = '0;
        rd    = 1'b0;
        wr    = 1'b0;
        wdata = result;
        case (st)
            ST_FETCH: begin
                addr = ip;
                rd   = 1'b1;
            end
            ST_OPRD: begin
                addr = field_addr;
                rd   = 1'b1;
            end
            ST_STORE: begin
                addr = field_addr;
                wr   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fex_sequencer.sv
module fex_sequencer
    import fex_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_rd,
    output logic                     mem_wr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata,
    input  logic                     mem_ready,
    output logic                     alu_go,
    output logic [DATA_W-ADDR_W-1:0] alu_opcode,
    output logic [DATA_W-1:0]        alu_operand,
    input  logic                     alu_done,
    input  logic [DATA_W-1:0]        alu_result,
    output logic [ADDR_W-1:0]        ip,
    output logic [5:0]               state
);
    localparam int OPC_W = DATA_W - ADDR_W;

    typedef struct packed {
        fex_state_e        st;
        logic [ADDR_W-1:0] ip;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] opnd;
        logic [DATA_W-1:0] res;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_FETCH, ip: '0, ir: '0, opnd: '0, res: '0};

    seq_t     seq_d, seq_q;
    fex_dec_t dec;

    fex_decode #(.OPC_W(OPC_W)) i_decode (
        .opc (seq_q.ir[DATA_W-1 -: OPC_W]),
        .dec (dec)
    );

    fex_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem_port (
        .st         (seq_q.st),
        .ip         (seq_q.ip),
        .field_addr (seq_q.ir[ADDR_W-1:0]),
        .result     (seq_q.res),
        .addr       (mem_addr),
        .rd         (mem_rd),
        .wr         (mem_wr),
        .wdata      (mem_wdata)
    );

    // Next-state and datapath selection for all phases.
    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_FETCH: begin
                if (mem_ready) begin
                    seq_d.ir = mem_rdata;
                    seq_d.ip = seq_q.ip + 1'b1;
                    seq_d.st = ST_DECODE;
                end
            end
            ST_DECODE: begin
                if (dec.halt)            seq_d.st = ST_HALT;
                else if (dec.rd_operand) seq_d.st = ST_OPRD;
                else                     seq_d.st = ST_EXEC;
            end
            ST_OPRD: begin
                if (mem_ready) begin
                    seq_d.opnd = mem_rdata;
                    seq_d.st   = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (alu_done) begin
                    seq_d.res = alu_result;
                    seq_d.st  = dec.wr_result ? ST_STORE : ST_FETCH;
                end
            end
            ST_STORE: begin
                if (mem_ready) seq_d.st = ST_FETCH;
            end
            ST_HALT: seq_d.st = ST_HALT;
            default: seq_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= SEQ_RST;
        else     seq_q <= seq_d;
    end

    always_comb begin
        alu_go      = (seq_q.st == ST_EXEC);
        alu_opcode  = seq_q.ir[DATA_W-1 -: OPC_W];
        alu_operand = seq_q.opnd;
        ip          = seq_q.ip;
        state       = seq_q.st;
    end
endmodule

// File: rtl/fex_sequencer_chk.sv
module fex_sequencer_chk
    import fex_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic              alu_go,
    input logic              alu_done,
    input logic [ADDR_W-1:0] ip,
    input logic [5:0]        state
);
    assert_onehot_state_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);

    assert_no_dual_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_fetch_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && !mem_ready) |=> (state == ST_FETCH && $stable(ip)));

    assert_ip_step_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && mem_ready) |=> (ip == $past(ip) + 1'b1));

    assert_decode_once_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE) |=> (state != ST_DECODE));

    assert_exec_wait_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && !alu_done) |=> (state == ST_EXEC && alu_go));

    assert_store_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STORE && !mem_ready) |=> (state == ST_STORE && mem_wr));

    assert_halt_park_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |=> (state == ST_HALT && !mem_rd && !mem_wr && $stable(ip)));
endmodule

bind fex_sequencer fex_sequencer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_ready (mem_ready),
    .alu_go    (alu_go),
    .alu_done  (alu_done),
    .ip        (ip),
    .state     (state)
);

// File: tb/test_fex_sequencer.sv
module test_fex_sequencer;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int OPC_W  = DATA_W - ADDR_W;
    localparam int TMAX   = 64;

    localparam logic [5:0] S_F = 6'b000001, S_D = 6'b000010, S_R = 6'b000100,
                           S_E = 6'b001000, S_S = 6'b010000, S_H = 6'b100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd, mem_wr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_ready = 1'b0;
    logic              alu_go;
    logic [OPC_W-1:0]  alu_opcode;
    logic [DATA_W-1:0] alu_operand;
    logic              alu_done = 1'b0;
    logic [DATA_W-1:0] alu_result = '0;
    logic [ADDR_W-1:0] ip;
    logic [5:0]        state;

    fex_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_fex_sequencer (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .alu_go(alu_go), .alu_opcode(alu_opcode), .alu_operand(alu_operand),
        .alu_done(alu_done), .alu_result(alu_result), .ip(ip), .state(state)
    );

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] bmem [64];
    int                mem_lat = 0, alu_lat = 0, mcnt = 0, acnt = 0;
    int                wr_cnt = 0;
    logic [ADDR_W-1:0] last_waddr;
    logic [DATA_W-1:0] last_wdata;

    logic              logging = 1'b0;
    int                tn = 0;
    logic [5:0]        t_st [TMAX];
    logic [ADDR_W-1:0] t_ip [TMAX], t_addr [TMAX];
    logic [2:0]        t_sb [TMAX];
    logic [DATA_W-1:0] t_op [TMAX];

    int                en = 0;
    logic [5:0]        e_st [TMAX];
    logic [ADDR_W-1:0] e_ip [TMAX], e_addr [TMAX];
    logic [2:0]        e_sb [TMAX];
    logic [DATA_W-1:0] e_op [TMAX];

    initial forever #5 clk = ~clk;

    // Memory responder: ready after mem_lat waiting cycles of a request.
    initial forever begin
        @(negedge clk);
        if (rst || !(mem_rd || mem_wr)) begin
            mem_ready = 1'b0; mcnt = 0;
        end else if (mcnt == mem_lat) begin
            mem_ready = 1'b1; mcnt = 0;
            mem_rdata = bmem[mem_addr[5:0]];
            if (mem_wr) begin
                bmem[mem_addr[5:0]] = mem_wdata;
                wr_cnt++;
                last_waddr = mem_addr;
                last_wdata = mem_wdata;
            end
        end else begin
            mem_ready = 1'b0; mcnt++;
        end
    end

    // Arithmetic responder: result is operand plus 0x0101.
    initial forever begin
        @(negedge clk);
        if (rst || !alu_go) begin
            alu_done = 1'b0; acnt = 0;
        end else if (acnt == alu_lat) begin
            alu_done = 1'b1; acnt = 0;
            alu_result = alu_operand + 16'h0101;
        end else begin
            alu_done = 1'b0; acnt++;
        end
    end

    // Per-cycle trace of the block's outputs.
    initial forever begin
        @(negedge clk);
        if (logging && !rst && tn < TMAX) begin
            t_st[tn] = state; t_ip[tn] = ip; t_addr[tn] = mem_addr;
            t_sb[tn] = {mem_rd, mem_wr, alu_go}; t_op[tn] = alu_operand;
            tn++;
        end
    end

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        logging = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic push(input logic [5:0] s, input logic [ADDR_W-1:0] p,
                        input logic [ADDR_W-1:0] a, input logic [2:0] sb,
                        input logic [DATA_W-1:0] op);
        if (en < TMAX) begin
            e_st[en] = s; e_ip[en] = p; e_addr[en] = a; e_sb[en] = sb; e_op[en] = op;
            en++;
        end
    endtask

    // Model of the phase order from the requirements.
    task automatic build(input int n);
        logic [ADDR_W-1:0] pc = '0;
        logic [DATA_W-1:0] w;
        logic [DATA_W-1:0] opnd = '0;
        logic [OPC_W-1:0]  opc;
        en = 0;
        while (en < n) begin
            w = bmem[pc[5:0]];
            for (int i = 0; i <= mem_lat; i++) push(S_F, pc, pc, 3'b100, opnd);
            pc = pc + 1'b1;
            push(S_D, pc, '0, 3'b000, opnd);
            opc = w[DATA_W-1 -: OPC_W];
            if (&opc) begin
                while (en < n) push(S_H, pc, '0, 3'b000, opnd);
            end else begin
                if (opc[0]) begin
                    for (int i = 0; i <= mem_lat; i++) push(S_R, pc, w[ADDR_W-1:0], 3'b100, opnd);
                    opnd = bmem[w[5:0]];
                end
                for (int i = 0; i <= alu_lat; i++) push(S_E, pc, '0, 3'b001, opnd);
                if (opc[1])
                    for (int i = 0; i <= mem_lat; i++) push(S_S, pc, w[ADDR_W-1:0], 3'b010, opnd);
            end
        end
    endtask

    function automatic string req_of(input logic [5:0] s);
        case (s)
            S_F: return "R2";
            S_D: return "R3";
            S_R: return "R5";
            S_E: return "R6";
            S_S: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic run_compare(input int ml, input int al, input int n);
        mem_lat = ml; alu_lat = al; wr_cnt = 0;
        build(n);
        tn = 0;
        do_reset();
        logging = 1'b1;
        while (tn < n) @(posedge clk);
        logging = 1'b0;
        for (int i = 0; i < n; i++) begin
            check(t_st[i] == e_st[i], (e_st[i] == S_R || e_st[i] == S_S) ? "R4" : req_of(e_st[i]),
                  $sformatf("state cycle %0d", i), 32'(t_st[i]), 32'(e_st[i]));
            check(t_ip[i] == e_ip[i] && t_sb[i] == e_sb[i], req_of(e_st[i]) == "R9" ? "R9" : "R8",
                  $sformatf("ip/strobes cycle %0d", i),
                  {17'(t_ip[i]), 3'(t_sb[i])}, {17'(e_ip[i]), 3'(e_sb[i])});
            if (e_sb[i][2:1] != 2'b00)
                check(t_addr[i] == e_addr[i], req_of(e_st[i]),
                      $sformatf("address cycle %0d", i), 32'(t_addr[i]), 32'(e_addr[i]));
            if (e_st[i] == S_E)
                check(t_op[i] == e_op[i], "R5", $sformatf("operand cycle %0d", i),
                      32'(t_op[i]), 32'(e_op[i]));
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) bmem[i] = 16'hF000;
    endtask

    task automatic t_reset();
        clear_mem();
        mem_lat = 5; alu_lat = 0;
        do_reset();
        @(negedge clk);
        // R1: fetch state, pointer and operand cleared
        check(state == S_F, "R1", "state after reset", 32'(state), 32'(S_F));
        check(ip == '0, "R1", "ip after reset", 32'(ip), 0);
        check(alu_operand == '0, "R1", "operand after reset", 32'(alu_operand), 0);
        check(mem_rd && mem_addr == '0, "R2", "first fetch request", {mem_rd, 31'(mem_addr)}, 32'h80000000);
    endtask

    task automatic t_regonly();
        clear_mem();
        bmem[0] = 16'h0000; bmem[1] = 16'h0000; bmem[2] = 16'h4000;
        run_compare(0, 0, 20);
        check(wr_cnt == 0, "R7", "writes without store bit", wr_cnt, 0);
    endtask

    task automatic t_load();
        clear_mem();
        bmem[0] = 16'h1021; bmem[16'h21] = 16'h4000;
        run_compare(0, 0, 16);
    endtask

    task automatic t_store();
        clear_mem();
        bmem[0] = 16'h2030;
        run_compare(0, 0, 16);
        // R7: operand still zero after reset, so result is 0x0101
        check(wr_cnt == 1, "R7", "write count", wr_cnt, 1);
        check(last_waddr == 12'h030 && last_wdata == 16'h0101, "R7", "write addr/data",
              {4'h0, last_waddr, last_wdata}, 32'h00300101);
    endtask

    task automatic t_rmw_slow();
        clear_mem();
        bmem[0] = 16'h3025; bmem[16'h25] = 16'h1234;
        run_compare(3, 4, 36);
        check(bmem[16'h25] == 16'h1335, "R6", "result written back", 32'(bmem[16'h25]), 32'h1335);
    endtask

    task automatic t_halt();
        clear_mem();
        bmem[0] = 16'hF000; bmem[1] = 16'h1021;
        run_compare(1, 0, 24);
        // R9: parked, nothing fetched after the halt word
        check(state == S_H && ip == 12'd1, "R9", "parked state/ip", {state, 26'(ip)}, {S_H, 26'd1});
    endtask

    task automatic t_mix();
        clear_mem();
        bmem[0] = 16'h1021; bmem[1] = 16'h0000; bmem[2] = 16'h2031; bmem[3] = 16'h3022;
        bmem[16'h21] = 16'h0010; bmem[16'h22] = 16'h0200;
        run_compare(1, 2, 50);
        check(wr_cnt == 2, "R7", "mixed write count", wr_cnt, 2);
        check(bmem[16'h31] == 16'h0111, "R5", "held operand reused", 32'(bmem[16'h31]), 32'h0111);
        check(bmem[16'h22] == 16'h0301, "R4", "read-modify-write", 32'(bmem[16'h22]), 32'h0301);
    endtask

    initial begin
        t_reset();
        t_regonly();
        t_load();
        t_store();
        t_rmw_slow();
        t_halt();
        t_mix();
        // R10 one-hot state is covered by every state compare above
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule